// File: doc/BRIEF.md
# ADC Window Watchdog Comparator

This block sits beside an analog-to-digital converter and checks every finished conversion against a programmable window made of a low and a high bound. When a checked result falls outside that window, the block sets a sticky status flag. An interrupt line follows the flag only while its enable input is high. Software clears the flag by pulsing a write-one-to-clear strobe.

The watchdog can be switched off, can watch one chosen channel, or can watch every channel. Both bounds are always 12 bits wide and weighted from bit 11 down. A result taken at a lower resolution is moved up to that weighting before the comparison, so one pair of bounds holds the same meaning at every resolution.

Top module: `awd_window_cmp`

## Requirements
- R1: `wd_mode` selects 0 = off, 1 = one channel, 2 = every channel; the value 3 is reserved and acts as off. While the mode is off, no result sets the flag.
- R2: In one-channel mode, only a result whose `res_chan` equals `wd_chan` is checked. Results from other channels never set the flag.
- R3: In every-channel mode, a result from any channel number is checked.
- R4: `res_sel` gives the resolution: 0 = 12, 1 = 10, 2 = 8, 3 = 6 bits. The right-aligned `res_data` is shifted left by 0, 2, 4 or 6 bits to match. Bits that leave the 12-bit field are dropped, so bits of `res_data` at or above the active resolution have no effect.
- R5: An aligned result is outside the window when it is strictly above `thr_hi` or strictly below `thr_lo`. A result equal to either bound is inside.
- R6: A checked result that is outside the window sets `flag_o` from the clock edge that samples `res_valid`. The flag then stays set, even after later results that fall inside the window.
- R7: A `flag_clr` pulse clears `flag_o` at the next clock edge. If a new out-of-window result arrives at the same edge, the flag stays set.
- R8: `irq_o` is high exactly when `flag_o` is high and `irq_en` is high. It follows `irq_en` with no clock delay.
- R9: After reset, `flag_o` and `irq_o` are low.
- R10: While `res_valid` is low, `res_data` and `res_chan` have no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | One-cycle strobe: a conversion result is present |
| res_data | input | 12 | Conversion result, right-aligned at the active resolution |
| res_chan | input | 5 | Channel number of the result |
| wd_mode | input | 2 | Watchdog mode (off / one channel / every channel) |
| wd_chan | input | 5 | Channel watched in one-channel mode |
| res_sel | input | 2 | Active resolution code |
| thr_hi | input | 12 | High bound, weighted from bit 11 |
| thr_lo | input | 12 | Low bound, weighted from bit 11 |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| flag_o | output | 1 | Sticky out-of-window flag |
| irq_o | output | 1 | Gated watchdog interrupt |

## Verification
The results driven at the 12-bit resolution lie inside the window, exactly on each bound, and one step beyond each bound. Together these show strict comparison apart from inclusive comparison, and test the high and low sides separately. The same values are then sent at 10, 8 and 6 bits. These runs show whether the shift is correct and whether bits above the active resolution are really dropped. Mode runs send out-of-window values while the mode is off, reserved, one-channel with both matching and non-matching channels, and every-channel, which separates the channel filter from the comparison. The last runs cover a clear pulse at the same edge as a new event, and data that changes while the valid strobe is low. These show the set-over-clear priority and confirm that the strobe gates every check.

// File: rtl/awd_pkg.sv
package awd_pkg;

    typedef enum logic [1:0] {
        AWD_OFF = 2'd0,
        AWD_ONE = 2'd1,
        AWD_ALL = 2'd2,
        AWD_RSV = 2'd3
    } awd_mode_e;

    typedef struct packed {
        logic flag;
    } awd_state_t;

endpackage

// File: rtl/awd_align.sv
module awd_align #(
    parameter int DATA_W   = 12,
    parameter int RES_STEP = 2
) (
    input  logic [1:0]        res_sel,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] aligned
);
    localparam int SH_W = $clog2(3 * RES_STEP + 1);

    logic [SH_W-1:0] shamt;

    always_comb begin
        shamt   = SH_W'(res_sel) * SH_W'(RES_STEP);
        aligned = raw << shamt;
    end
endmodule

// File: rtl/awd_chan_sel.sv
module awd_chan_sel
    import awd_pkg::*;
#(
    parameter int CH_W = 5
) (
    input  logic            res_valid,
    input  logic [1:0]      wd_mode,
    input  logic [CH_W-1:0] wd_chan,
    input  logic [CH_W-1:0] res_chan,
    output logic            watched
);
    always_comb begin
        unique case (awd_mode_e'(wd_mode))
            AWD_ONE: watched = res_valid && (res_chan == wd_chan);
            AWD_ALL: watched = res_valid;
            default: watched = 1'b0;
        endcase
    end
endmodule

// File: rtl/awd_window.sv
module awd_window #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic [DATA_W-1:0] thr_lo,
    output logic              outside
);
    logic above, below;

    always_comb begin
        above   = value > thr_hi;
        below   = value < thr_lo;
        outside = above || below;
    end
endmodule

// File: rtl/awd_window_cmp.sv
module awd_window_cmp
    import awd_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter int CH_W     = 5,
    parameter int RES_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [CH_W-1:0]   res_chan,
    input  logic [1:0]        wd_mode,
    input  logic [CH_W-1:0]   wd_chan,
    input  logic [1:0]        res_sel,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic [DATA_W-1:0] thr_lo,
    input  logic              irq_en,
    input  logic              flag_clr,
    output logic              flag_o,
    output logic              irq_o
);
    logic [DATA_W-1:0] aligned;
    logic              watched;
    logic              outside;
    logic              hit;
    awd_state_t        st_d, st_q;

    awd_align #(.DATA_W(DATA_W), .RES_STEP(RES_STEP)) align_i (
        .res_sel (res_sel),
        .raw     (res_data),
        .aligned (aligned)
    );

    awd_chan_sel #(.CH_W(CH_W)) sel_i (
        .res_valid (res_valid),
        .wd_mode   (wd_mode),
        .wd_chan   (wd_chan),
        .res_chan  (res_chan),
        .watched   (watched)
    );

    awd_window #(.DATA_W(DATA_W)) win_i (
        .value   (aligned),
        .thr_hi  (thr_hi),
        .thr_lo  (thr_lo),
        .outside (outside)
    );

    // A new event takes priority over a clear at the same edge.
    always_comb begin
        hit  = watched && outside;
        st_d = st_q;
        if (hit) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & irq_en;
endmodule

// File: rtl/awd_window_cmp_chk.sv
module awd_window_cmp_chk #(
    parameter int DATA_W = 12,
    parameter int CH_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic [CH_W-1:0]   res_chan,
    input logic [1:0]        wd_mode,
    input logic [CH_W-1:0]   wd_chan,
    input logic [DATA_W-1:0] thr_hi,
    input logic [DATA_W-1:0] thr_lo,
    input logic              irq_en,
    input logic              flag_clr,
    input logic              flag_o,
    input logic              irq_o
);
    AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && (wd_mode == 2'd0 || wd_mode == 2'd3)) |=> !flag_o); // R1

    AST_OTHER_CHAN_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && wd_mode == 2'd1 && res_chan != wd_chan) |=> !flag_o); // R2

    AST_FULL_WINDOW_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && thr_lo == '0 && thr_hi == '1) |=> !flag_o); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr) |=> flag_o); // R6

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !res_valid) |=> !flag_o); // R7

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_o); // R8

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o); // R8

    AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !res_valid) |=> !flag_o); // R10
endmodule

bind awd_window_cmp awd_window_cmp_chk #(.DATA_W(DATA_W), .CH_W(CH_W)) chk_i (.*);

// File: tb/awd_window_cmp_tb_top.sv
`timescale 1ns/1ps
module awd_window_cmp_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;
    logic [4:0]  res_chan = '0;
    logic [1:0]  wd_mode = 2'd0;
    logic [4:0]  wd_chan = '0;
    logic [1:0]  res_sel = 2'd0;
    logic [11:0] thr_hi = 12'hFFF;
    logic [11:0] thr_lo = 12'h000;
    logic        irq_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        flag_o, irq_o;

    int total = 0;
    int bad = 0;
    bit exp_flag = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    awd_window_cmp dut_i (.*);

    // Behavioural reference model, one update per clock edge.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_flag <= 1'b0;
        end else begin
            int  sh;
            int  val;
            bit  mon;
            bit  oow;
            sh  = 2 * int'(res_sel);
            val = (int'(res_data) * (1 << sh)) % 4096;
            mon = res_valid && ((wd_mode == 2'd2) || (wd_mode == 2'd1 && res_chan == wd_chan));
            oow = (val > int'(thr_hi)) || (val < int'(thr_lo));
            if (mon && oow) exp_flag <= 1'b1;
            else if (flag_clr) exp_flag <= 1'b0;
        end
    end

    task automatic chk(input bit got, input bit exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(flag_o, exp_flag, "R6 model flag");
            chk(irq_o, exp_flag && irq_en, "R8 model irq");
        end
    end

    task automatic send(input logic [11:0] d, input logic [4:0] c);
        @(negedge clk); #1;
        res_valid = 1'b1; res_data = d; res_chan = c;
        @(negedge clk); #1;
        res_valid = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk); #1;
        flag_clr = 1'b1;
        @(negedge clk); #1;
        flag_clr = 1'b0;
    endtask

    initial begin
        #20000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(flag_o, 1'b0, "R9 reset flag");
        chk(irq_o, 1'b0, "R9 reset irq");
        #1 rst_n = 1'b1;

        // Every-channel mode, 12-bit, window 0x100..0x800
        wd_mode = 2'd2; thr_lo = 12'h100; thr_hi = 12'h800;
        send(12'h400, 5'd7);   chk(flag_o, 1'b0, "R5 inside");
        send(12'h800, 5'd7);   chk(flag_o, 1'b0, "R5 equal high");
        send(12'h100, 5'd2);   chk(flag_o, 1'b0, "R5 equal low");
        send(12'h801, 5'd11);  chk(flag_o, 1'b1, "R3 above high any channel");
        send(12'h400, 5'd11);  chk(flag_o, 1'b1, "R6 sticky");
        chk(irq_o, 1'b0, "R8 irq gated off");
        irq_en = 1'b1; #0.5;
        chk(irq_o, 1'b1, "R8 irq immediate");
        clear();               chk(flag_o, 1'b0, "R7 clear");
        chk(irq_o, 1'b0, "R8 irq follows clear");
        send(12'h0FF, 5'd0);   chk(flag_o, 1'b1, "R5 below low");
        clear();

        // Off and reserved modes
        wd_mode = 2'd0;
        send(12'hFFF, 5'd1);   chk(flag_o, 1'b0, "R1 mode off");
        wd_mode = 2'd3;
        send(12'h000, 5'd1);   chk(flag_o, 1'b0, "R1 reserved mode");

        // One-channel mode on channel 18
        wd_mode = 2'd1; wd_chan = 5'd18;
        send(12'hFFF, 5'd3);   chk(flag_o, 1'b0, "R2 other channel");
        send(12'hFFF, 5'd17);  chk(flag_o, 1'b0, "R2 neighbour channel");
        send(12'hFFF, 5'd18);  chk(flag_o, 1'b1, "R2 watched channel");
        clear();

        // Resolution alignment
        wd_mode = 2'd2;
        res_sel = 2'd1;
        send(12'h200, 5'd4);   chk(flag_o, 1'b0, "R4 10-bit at bound");
        send(12'h201, 5'd4);   chk(flag_o, 1'b1, "R4 10-bit above");
        clear();
        res_sel = 2'd3;
        send(12'h020, 5'd4);   chk(flag_o, 1'b0, "R4 6-bit at bound");
        send(12'h021, 5'd4);   chk(flag_o, 1'b1, "R4 6-bit above");
        clear();
        res_sel = 2'd2;
        send(12'hF20, 5'd4);   chk(flag_o, 1'b0, "R4 upper bits dropped");
        send(12'h00F, 5'd4);   chk(flag_o, 1'b1, "R4 8-bit below low");
        res_sel = 2'd0;

        // Clear and new event at the same edge
        @(negedge clk); #1;
        flag_clr = 1'b1; res_valid = 1'b1; res_data = 12'hFFF;
        @(negedge clk); #1;
        flag_clr = 1'b0; res_valid = 1'b0;
        chk(flag_o, 1'b1, "R7 set wins over clear");
        clear();

        // Data changes without valid
        @(negedge clk); #1; res_data = 12'hFFF; res_chan = 5'd9;
        @(negedge clk); #1; res_data = 12'h000;
        @(negedge clk);
        chk(flag_o, 1'b0, "R10 no valid no effect");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule